// File: doc/BRIEF.md
# Embedded Operation Status Poller

This block sits in the read path of a flash-like storage device while an internally timed word program or block erase is running. A start pulse, together with the operation kind, the word being programmed and the word currently stored at the target, opens a busy window. The window lasts a fixed number of clock cycles, and each operation kind has its own cycle-count parameter. During that window every read returns the array data with two bits replaced by completion status. The poll bit carries the inverse of the programmed value for a program and a constant zero for an erase. The toggle bit inverts after every read access. Once the window closes, reads return plain array data again.

When a program finishes, the block emits a one-cycle commit carrying the word to store. Programming can only clear bits, so that word is the bitwise AND of the old and new words. An abort input ends the window early. An aborted program commits a fixed garbage pattern in place of the target word. An aborted erase simply stops. The array itself, command decoding and pulse generation are handled by neighbouring logic.

Top module: `emb_status_poller`

## Requirements
- R1: After a start with op_erase_i=0 is sampled while idle, busy_o is high for exactly PROG_CYCLES consecutive cycles, beginning in the cycle after the start edge.
- R2: After a start with op_erase_i=1 is sampled while idle, busy_o is high for exactly ERASE_CYCLES consecutive cycles.
- R3: While a program is busy, bit POLL_BIT (default 7) of rd_data_o equals the inverse of bit POLL_BIT of the wdata_i captured at start.
- R4: While an erase is busy, bit POLL_BIT of rd_data_o reads 0 on every access.
- R5: Bit TGL_BIT (default 6) of rd_data_o shows a toggle state during busy. The state is 0 after reset, inverts after each cycle in which rd_stb_i is high while busy, and holds in all other cycles, idle ones included.
- R6: All bits other than POLL_BIT and TGL_BIT always equal arr_rdata_i. When idle, every bit equals arr_rdata_i.
- R7: When a program completes, commit_o is high for exactly the one cycle in which busy_o has just fallen, and commit_data_o = old_word_i & wdata_i as captured at start. An erase completion produces no commit.
- R8: A start pulse seen while busy is ignored. The window length, the operation kind and the captured data do not change.
- R9: halt_i seen during a program makes busy_o fall on the next edge and commits ABORT_PATTERN (default 16'h0F0F) in that cycle.
- R10: halt_i seen during an erase ends busy on the next edge with no commit. halt_i while idle has no effect. A start that coincides with halt_i is dropped.
- R11: After reset, busy_o and commit_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle start request |
| op_erase_i | input | 1 | Operation kind at start: 0 program, 1 erase |
| wdata_i | input | DATA_W | Word being programmed, captured at start |
| old_word_i | input | DATA_W | Word stored at the target, captured at start |
| halt_i | input | 1 | Aborts a running operation |
| rd_stb_i | input | 1 | Read access in this cycle |
| arr_rdata_i | input | DATA_W | Array data for the current read address |
| rd_data_o | output | DATA_W | Read bus, combinational from arr_rdata_i and status |
| busy_o | output | 1 | Operation in progress |
| commit_o | output | 1 | One-cycle pulse: commit_data_o is to be written to the target |
| commit_data_o | output | DATA_W | Word to store on program completion or abort |

## Verification
Read data is combinational, so a read's expected value is due in the same cycle as its strobe. The toggle state it changes is visible from the next cycle on. busy_o rises one edge after the start edge and falls PROG_CYCLES or ERASE_CYCLES edges after that, or one edge after halt_i. commit_o shows up in the first cycle in which busy_o is low. The driver queues each expected read word, commit word and busy length as it drives the stimulus. A monitor samples on the falling clock edge and pops an entry only when the design shows a strobed read, a commit pulse or a busy fall. A result that comes a cycle early or late, or never comes, is therefore caught against the wrong or a missing entry.

// File: rtl/esp_pkg.sv
package esp_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/esp_rst_sync.sv
module esp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/esp_op_timer.sv
module esp_op_timer
  import esp_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 400
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  op_kind_e op_i,
  input  logic     halt_i,
  output logic     busy_o,
  output op_kind_e op_o,
  output logic     accept_o,
  output logic     done_o,
  output logic     abort_o
);
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  op_kind_e      op_q, op_d;
  logic          cnt_en;

  assign accept_o = start_i & ~busy_q & ~halt_i;
  assign abort_o  = busy_q & halt_i;
  assign done_o   = busy_q & ~halt_i & (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    cnt_en = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      op_d   = op_i;
      cnt_d  = (op_i == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
      cnt_en = 1'b1;
    end else if (abort_o || done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        op_q  <= op_d;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;

  // R1: the window opens only on a start that was not halted
  p_rise_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(start_i) && !$past(halt_i)));

  // R8: a start while busy changes neither the state nor the kind
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !halt_i && cnt_q != '0) |=> (busy_q && $stable(op_q)));

  // R9 / R10: halt ends the window on the next edge
  p_halt_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && halt_i) |=> !busy_q);

  // R2: counter never exceeds the longest window
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CW'(MAXC - 1)));
endmodule

// File: rtl/esp_op_capture.sv
module esp_op_capture
  import esp_pkg::*;
#(
  parameter int unsigned       DATA_W        = 16,
  parameter logic [DATA_W-1:0] ABORT_PATTERN = 16'h0F0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic              done_i,
  input  logic              abort_i,
  input  op_kind_e          op_q_i,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic [DATA_W-1:0] wdata_q, old_q;
  logic              commit_q, commit_d;
  logic [DATA_W-1:0] cdata_q, cdata_d;

  always_comb begin
    commit_d = (done_i || abort_i) && (op_q_i == OP_PROG);
    cdata_d  = abort_i ? ABORT_PATTERN : (old_q & wdata_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q  <= '0;
      old_q    <= '0;
      commit_q <= 1'b0;
      cdata_q  <= '0;
    end else begin
      commit_q <= commit_d;
      if (accept_i) begin
        wdata_q <= wdata_i;
        old_q   <= old_i;
      end
      if (commit_d) cdata_q <= cdata_d;
    end
  end

  assign wdata_q_o     = wdata_q;
  assign commit_o      = commit_q;
  assign commit_data_o = cdata_q;

  // R7: a commit is always a single-cycle pulse
  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R8: captured data changes only when a start is accepted
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> ($stable(wdata_q) && $stable(old_q)));
endmodule

// File: rtl/esp_toggle.sv
module esp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_stb_i,
  output logic tgl_o
);
  logic tgl_q, tgl_d, tgl_en;

  always_comb begin
    tgl_en = busy_i & rd_stb_i;
    tgl_d  = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgl_q <= 1'b0;
    else if (tgl_en) tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;

  // R5: no busy read, no change
  p_tgl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_i && rd_stb_i) |=> $stable(tgl_q));

  // R5: every busy read inverts the state
  p_tgl_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_stb_i) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/esp_read_mux.sv
module esp_read_mux
  import esp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6
) (
  input  logic              busy_i,
  input  op_kind_e          op_i,
  input  logic              poll_ref_i,
  input  logic              tgl_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign rd_data_o[i] = busy_i ? ((op_i == OP_ERASE) ? 1'b0 : ~poll_ref_i) : arr_i[i];
    end else if (i == TGL_BIT) begin : g_tgl
      assign rd_data_o[i] = busy_i ? tgl_i : arr_i[i];
    end else begin : g_pass
      assign rd_data_o[i] = arr_i[i];
    end
  end
endmodule

// File: rtl/emb_status_poller.sv
module emb_status_poller
  import esp_pkg::*;
#(
  parameter int unsigned       DATA_W        = 16,
  parameter int unsigned       PROG_CYCLES   = 40,
  parameter int unsigned       ERASE_CYCLES  = 400,
  parameter int unsigned       POLL_BIT      = 7,
  parameter int unsigned       TGL_BIT       = 6,
  parameter logic [DATA_W-1:0] ABORT_PATTERN = 16'h0F0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] old_word_i,
  input  logic              halt_i,
  input  logic              rd_stb_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic              srst_n;
  op_kind_e          op_in, op_q;
  logic              accept, done, abort, tgl;
  logic [DATA_W-1:0] wdata_q;

  assign op_in = op_kind_e'(op_erase_i);

  esp_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  esp_op_timer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .start_i  (start_i),
    .op_i     (op_in),
    .halt_i   (halt_i),
    .busy_o   (busy_o),
    .op_o     (op_q),
    .accept_o (accept),
    .done_o   (done),
    .abort_o  (abort)
  );

  esp_op_capture #(
    .DATA_W        (DATA_W),
    .ABORT_PATTERN (ABORT_PATTERN)
  ) u_capture (
    .clk           (clk),
    .rst_n         (srst_n),
    .accept_i      (accept),
    .wdata_i       (wdata_i),
    .old_i         (old_word_i),
    .done_i        (done),
    .abort_i       (abort),
    .op_q_i        (op_q),
    .wdata_q_o     (wdata_q),
    .commit_o      (commit_o),
    .commit_data_o (commit_data_o)
  );

  esp_toggle u_toggle (
    .clk      (clk),
    .rst_n    (srst_n),
    .busy_i   (busy_o),
    .rd_stb_i (rd_stb_i),
    .tgl_o    (tgl)
  );

  esp_read_mux #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
  ) u_mux (
    .busy_i     (busy_o),
    .op_i       (op_q),
    .poll_ref_i (wdata_q[POLL_BIT]),
    .tgl_i      (tgl),
    .arr_i      (arr_rdata_i),
    .rd_data_o  (rd_data_o)
  );

  // R7: commit appears only in the cycle right after busy falls
  p_commit_on_fall_r7: assert property (@(posedge clk) disable iff (!srst_n)
    commit_o |-> (!busy_o && $past(busy_o)));

  // R6: when idle the read bus is the array word
  p_idle_passthru_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !busy_o |-> (rd_data_o == arr_rdata_i));

  // R10: halt while idle keeps the block idle
  p_idle_halt_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_o && halt_i) |=> !busy_o);
endmodule

// File: tb/emb_status_poller_bench.sv
module emb_status_poller_bench;
  localparam int PC = 12;
  localparam int EC = 30;
  localparam logic [15:0] ABORT = 16'h0F0F;

  logic        clk = 1'b0;
  logic        rst_n, start_i, op_erase_i, halt_i, rd_stb_i;
  logic [15:0] wdata_i, old_word_i, arr_rdata_i;
  logic [15:0] rd_data_o, commit_data_o;
  logic        busy_o, commit_o;

  always #2 clk = ~clk;

  emb_status_poller #(
    .DATA_W (16), .PROG_CYCLES (PC), .ERASE_CYCLES (EC),
    .POLL_BIT (7), .TGL_BIT (6), .ABORT_PATTERN (ABORT)
  ) u_emb_status_poller (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_erase_i (op_erase_i),
    .wdata_i (wdata_i), .old_word_i (old_word_i), .halt_i (halt_i),
    .rd_stb_i (rd_stb_i), .arr_rdata_i (arr_rdata_i), .rd_data_o (rd_data_o),
    .busy_o (busy_o), .commit_o (commit_o), .commit_data_o (commit_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [15:0] rd_q[$];  string rd_tag[$];
  logic [15:0] cm_q[$];  string cm_tag[$];
  int          len_q[$]; string len_tag[$];

  // bench model of the status state
  bit          m_busy = 0, m_erase = 0, m_tgl = 0;
  logic [15:0] m_wd = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expectations as results appear
  int  bcnt = 0;
  bit  bprev = 0;
  logic [15:0] me;
  string mt;
  int  ml;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_stb_i) begin
        if (rd_q.size() == 0) check(0, "R6 unexpected read", rd_data_o, 0);
        else begin
          me = rd_q.pop_front(); mt = rd_tag.pop_front();
          check(rd_data_o === me, mt, rd_data_o, me);
        end
      end
      if (commit_o) begin
        if (cm_q.size() == 0) check(0, "R7 unexpected commit", commit_data_o, 0);
        else begin
          me = cm_q.pop_front(); mt = cm_tag.pop_front();
          check(commit_data_o === me, mt, commit_data_o, me);
        end
      end
      if (busy_o) bcnt++;
      else if (bprev) begin
        if (len_q.size() == 0) check(0, "R1 unexpected busy window", bcnt, 0);
        else begin
          ml = len_q.pop_front(); mt = len_tag.pop_front();
          check(bcnt == ml, mt, bcnt, ml);
        end
        bcnt = 0;
      end
      bprev = busy_o;
    end
  end

  // driver tasks: each is entered 1 ns after a rising edge and returns likewise
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_read(input logic [15:0] arr, input string tag);
    logic [15:0] e;
    rd_stb_i = 1; arr_rdata_i = arr;
    e = arr;
    if (m_busy) begin
      e[6] = m_tgl;
      e[7] = m_erase ? 1'b0 : ~m_wd[7];
      m_tgl = ~m_tgl;
    end
    rd_q.push_back(e); rd_tag.push_back(tag);
    step(1);
    rd_stb_i = 0;
  endtask

  task automatic do_start(input bit er, input logic [15:0] wd, input logic [15:0] old,
                          input bit exp_commit, input int len, input string tag);
    start_i = 1; op_erase_i = er; wdata_i = wd; old_word_i = old;
    len_q.push_back(len); len_tag.push_back(tag);
    if (exp_commit) begin
      cm_q.push_back(old & wd); cm_tag.push_back("R7 commit word");
    end
    step(1);
    start_i = 0;
    m_busy = 1; m_erase = er; m_wd = wd;
  endtask

  task automatic wait_idle();
    while (busy_o) step(1);
    m_busy = 0;
  endtask

  task automatic do_halt();
    halt_i = 1;
    step(1);
    halt_i = 0;
    m_busy = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; start_i = 0; op_erase_i = 0; halt_i = 0; rd_stb_i = 0;
    wdata_i = '0; old_word_i = '0; arr_rdata_i = '0;
    step(3);
    rst_n = 1;
    step(4);
    @(negedge clk);
    check(busy_o == 0, "R11 busy after reset", busy_o, 0);
    check(commit_o == 0, "R11 commit after reset", commit_o, 0);
    step(1);
    do_read(16'h1234, "R6 idle read after reset");

    // program, bit7 of data = 1 -> poll reads 0; toggle 0,1,0,1
    do_start(0, 16'h00FF, 16'hF0F0, 1, PC, "R1 program busy length");
    do_read(16'hAAAA, "R3 program poll read 1");
    do_read(16'h5555, "R5 toggle read 2");
    do_read(16'hFFFF, "R5 toggle read 3");
    do_read(16'h0000, "R6 other bits read 4");
    wait_idle();
    do_read(16'hC3C3, "R6 idle after program");
    do_read(16'h3C3C, "R5 idle read no toggle");

    // program, bit7 = 0 -> poll reads 1; gap without reads holds toggle
    do_start(0, 16'h5A3C, 16'hFFFF, 1, PC, "R1 second program length");
    do_read(16'h0101, "R3 poll inverse of zero");
    step(3);
    do_read(16'h0202, "R5 toggle held across gap");
    wait_idle();

    // erase
    do_start(1, 16'hFFFF, 16'h0000, 0, EC, "R2 erase busy length");
    do_read(16'hFFFF, "R4 erase poll zero 1");
    do_read(16'hFFFF, "R4 erase poll zero 2");
    do_read(16'h8080, "R4 erase poll zero 3");
    wait_idle();
    do_read(16'hFFFF, "R6 idle after erase");

    // start while busy is ignored
    do_start(0, 16'h0055, 16'hFFFF, 1, PC, "R8 length unchanged by restart");
    step(2);
    start_i = 1; op_erase_i = 1; wdata_i = 16'h0000; old_word_i = 16'h0000;
    step(1);
    start_i = 0;
    do_read(16'h1111, "R8 kind and data unchanged");
    wait_idle();

    // halt during program
    do_start(0, 16'h1234, 16'hFFFF, 0, 4, "R9 aborted program length");
    step(3);
    cm_q.push_back(ABORT); cm_tag.push_back("R9 abort pattern");
    do_halt();
    do_read(16'h7777, "R9 idle after abort");

    // halt during erase
    do_start(1, 16'h0000, 16'h0000, 0, 6, "R10 aborted erase length");
    step(5);
    do_halt();
    do_read(16'h2468, "R10 idle after erase abort");

    // halt while idle, then start together with halt
    do_halt();
    do_read(16'h1357, "R10 halt while idle no effect");
    start_i = 1; halt_i = 1;
    step(1);
    start_i = 0; halt_i = 0;
    @(negedge clk);
    check(busy_o == 0, "R10 start with halt dropped", busy_o, 0);
    step(1);

    // read in the last busy cycle, then first idle cycle
    do_start(0, 16'h0080, 16'hFFFF, 1, PC, "R1 boundary program length");
    step(PC - 1);
    do_read(16'h4242, "R1 read in last busy cycle");
    wait_idle();
    do_read(16'h4242, "R1 read in first idle cycle");

    step(4);
    check(rd_q.size() == 0, "R6 reads left over", rd_q.size(), 0);
    check(cm_q.size() == 0, "R7 missing commit", cm_q.size(), 0);
    check(len_q.size() == 0, "R1 missing busy window", len_q.size(), 0);
    finish_run();
  end
endmodule